// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block watches the active-low clear-to-send input of a serial port and keeps a sticky flag that records whether that line has moved since software last read the modem status byte. The flag is cleared by the read itself, so a polling routine sees each change exactly once. The block also reports the present level of the line, inverted so that a 1 means "asserted".

When the port is put into loopback, the block stops listening to the pin. Its source becomes the request-to-send bit of the modem control register, so a driver can test its change handling without external wiring. The pin passes through a clock-domain synchroniser before any comparison. The comparison register resets to "deasserted", which means a line that is still asserted when reset ends is reported as a fresh change.

Top module: `modem_delta_tracker`

## Requirements
- R1: While reset is high, and after it is released with cts_n high and loopback off, the status byte reads 0x00.
- R2: In pin mode, a change of cts_n in either direction sets status bit 0 (delta) in the third rising edge after the change is applied.
- R3: A read strobe sampled at a rising edge clears bit 0 at that edge; the status byte seen during the strobe cycle still shows the value from before the clear.
- R4: If a change of the selected source is detected in the same cycle as a read strobe, bit 0 stays 1 after that edge.
- R5: Once set, bit 0 stays 1 until a read, no matter how many further changes occur.
- R6: With loopback on (loop_en=1), a change of mcr_rts sets bit 0 at the first rising edge after it, and changes of cts_n have no effect on bit 0.
- R7: With loopback on, status bit 4 (CTS) equals mcr_rts in the same cycle, with no register delay.
- R8: In pin mode, bit 4 is the inverse of cts_n delayed by two rising edges through the synchroniser.
- R9: If cts_n is held low through reset, bit 0 reads 0 during reset and becomes 1 at the third rising edge after reset is released.
- R10: Status bits 7:5 and 3:1 always read 0.
- R11: Switching loop_en between sources whose values differ counts as a change and sets bit 0 at the next rising edge; switching between equal values does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| loop_en | input | 1 | Loopback enable from the modem control register |
| mcr_rts | input | 1 | Request-to-send bit from the modem control register |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| msr_rdata | output | 8 | Status byte: bit 4 current CTS, bit 0 delta CTS |

## Verification
A wrong synchroniser depth or reset value shows as bit 4 or bit 0 moving one edge early or late after a pin change, or after reset release with the line held low. A flag register that drops a change shows up when a change and a read strobe meet: bit 0 reads 0 one cycle after the strobe when it should read 1. A wrong source selection shows immediately in loopback, where bit 4 no longer tracks mcr_rts in the same cycle and pin toggles start to set the flag.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int STATUS_W   = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int DELTA_POS  = 0;
    localparam int LEVEL_POS  = 4;

    // Status byte layout, MSB first
    typedef struct packed {
        logic [2:0] spare_hi;  // 7:5 placeholders
        logic       cts_lvl;   // 4
        logic [2:0] spare_lo;  // 3:1 placeholders
        logic       cts_delta; // 0
    } msr_t;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_LOOP = 1'b1
    } src_e;

    function automatic msr_t pack_msr(input logic lvl, input logic dlt);
        msr_t m;
        m           = '0;
        m.cts_lvl   = lvl;
        m.cts_delta = dlt;
        return m;
    endfunction

    function automatic src_e pick_src(input logic loop);
        return loop ? SRC_LOOP : SRC_PIN;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/msd_src_sel.sv
module msd_src_sel
    import msd_pkg::*;
(
    input  logic loop_en,
    input  logic pin_act,
    input  logic rts,
    output logic level
);
    src_e src;

    always_comb begin
        src = pick_src(loop_en);
        unique case (src)
            SRC_LOOP: level = rts;
            default:  level = pin_act;
        endcase
    end

endmodule

// File: rtl/msd_delta.sv
module msd_delta (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic rd_stb,
    output logic delta
);
    logic prev_q;
    logic delta_q;
    logic change;

    assign change = (level != prev_q);

    // prev_q resets to "deasserted" so a line asserted through reset is seen as a change
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            delta_q <= 1'b0;
        end else begin
            prev_q <= level;
            if (change)      delta_q <= 1'b1;
            else if (rd_stb) delta_q <= 1'b0;
        end
    end

    assign delta = delta_q;

    p_change_sets_r2: assert property (@(posedge clk) disable iff (rst)
        change |=> delta_q);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !change) |=> !delta_q);

    p_collide_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && change) |=> delta_q);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (delta_q && !rd_stb) |=> delta_q);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !delta_q);

endmodule

// File: rtl/modem_delta_tracker.sv
module modem_delta_tracker
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cts_n,
    input  logic                loop_en,
    input  logic                mcr_rts,
    input  logic                rd_stb,
    output logic [STATUS_W-1:0] msr_rdata
);
    localparam logic [STATUS_W-1:0] SPARE_MASK =
        ~((STATUS_W'(1) << DELTA_POS) | (STATUS_W'(1) << LEVEL_POS));

    logic cts_n_sync;
    logic pin_act;
    logic sel_level;
    logic delta;
    msr_t status;

    msd_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cts_n),
        .q   (cts_n_sync)
    );

    assign pin_act = ~cts_n_sync;

    msd_src_sel u_sel (
        .loop_en (loop_en),
        .pin_act (pin_act),
        .rts     (mcr_rts),
        .level   (sel_level)
    );

    msd_delta u_delta (
        .clk    (clk),
        .rst    (rst),
        .level  (sel_level),
        .rd_stb (rd_stb),
        .delta  (delta)
    );

    always_comb begin
        status    = pack_msr(sel_level, delta);
        msr_rdata = status;
    end

    p_loop_level_r7: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (msr_rdata[LEVEL_POS] == mcr_rts));

    p_spare_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (msr_rdata & SPARE_MASK) == '0);

    p_loop_pin_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en) && $stable(mcr_rts) && !rd_stb && !msr_rdata[DELTA_POS])
            |=> !msr_rdata[DELTA_POS]);

endmodule

// File: tb/modem_delta_tracker_bench.sv
module modem_delta_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cts_n;
    logic       loop_en;
    logic       mcr_rts;
    logic       rd_stb;
    logic [7:0] msr_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_delta_tracker u_modem_delta_tracker (
        .clk       (clk),
        .rst       (rst),
        .cts_n     (cts_n),
        .loop_en   (loop_en),
        .mcr_rts   (mcr_rts),
        .rd_stb    (rd_stb),
        .msr_rdata (msr_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%02h exp=0x%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] seen);
        seen   = msr_rdata;
        rd_stb = 1'b1;
        cyc(1);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; cts_n = 1'b1; loop_en = 1'b0; mcr_rts = 1'b0; rd_stb = 1'b0;
        cyc(3);
        check("R1 in reset", msr_rdata, 8'h00);
        rst = 1'b0;
        cyc(4);
        check("R1 after release", msr_rdata, 8'h00);
    endtask

    task automatic t_pin_change;
        cts_n = 1'b0;
        cyc(1);
        check("R8 one edge", msr_rdata, 8'h00);
        cyc(1);
        check("R8 level after two edges", msr_rdata, 8'h10);
        cyc(1);
        check("R2 delta on third edge", msr_rdata, 8'h11);
        check("R10 spare bits", msr_rdata & 8'hEE, 8'h00);
    endtask

    task automatic t_sticky;
        cts_n = 1'b1;
        cyc(5);
        check("R5 sticky after rise", msr_rdata, 8'h01);
        cts_n = 1'b0;
        cyc(5);
        check("R5 sticky after second fall", msr_rdata, 8'h11);
    endtask

    task automatic t_read;
        logic [7:0] seen;
        do_read(seen);
        check("R3 data before clear", seen, 8'h11);
        check("R3 cleared by read", msr_rdata, 8'h10);
    endtask

    task automatic t_collide;
        logic [7:0] seen;
        cts_n = 1'b1;
        cyc(2);
        check("R8 level dropped", msr_rdata, 8'h00);
        do_read(seen);
        check("R4 change kept over read", msr_rdata, 8'h01);
        do_read(seen);
        check("R3 plain read clears", msr_rdata, 8'h00);
    endtask

    task automatic t_loop;
        logic [7:0] seen;
        loop_en = 1'b1;
        cyc(2);
        check("R11 equal switch no delta", msr_rdata, 8'h00);
        mcr_rts = 1'b1;
        #1;
        check("R7 level follows rts at once", msr_rdata, 8'h10);
        cyc(1);
        check("R6 rts change sets delta", msr_rdata, 8'h11);
        do_read(seen);
        cts_n = 1'b0;
        cyc(5);
        check("R6 pin ignored in loopback", msr_rdata, 8'h10);
        mcr_rts = 1'b0;
        cyc(1);
        check("R6 rts fall sets delta", msr_rdata, 8'h01);
        do_read(seen);
        check("R3 clear in loopback", msr_rdata, 8'h00);
        loop_en = 1'b0;
        #1;
        check("R8 pin level back", msr_rdata, 8'h10);
        cyc(1);
        check("R11 differing switch sets delta", msr_rdata, 8'h11);
        do_read(seen);
    endtask

    task automatic t_reset_held;
        rst = 1'b1;
        cyc(3);
        check("R9 quiet in reset", msr_rdata, 8'h00);
        rst = 1'b0;
        cyc(1);
        check("R9 one edge after release", msr_rdata, 8'h00);
        cyc(1);
        check("R9 level two edges after release", msr_rdata, 8'h10);
        cyc(1);
        check("R9 delta three edges after release", msr_rdata, 8'h11);
    endtask

    initial begin
        t_reset;
        t_pin_change;
        t_sticky;
        t_read;
        t_collide;
        t_loop;
        t_reset_held;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule